// File: doc/BRIEF.md
# Program Counter Next-Address and Call Frame Unit

This block works out where execution goes next for an 8-bit controller with a 16-bit program space. For each instruction the sequencer presents the current program counter, the instruction length, the form of control transfer, the operand bytes, and a taken/not-taken decision made elsewhere. The block returns the next program counter. It also handles the call forms, which need a return address pushed onto an 8-bit stack. For those it gives the two stack write addresses, the two return-address bytes and the stack pointer after the push.

Sequential flow adds the instruction length to the PC. The in-page forms keep the upper five bits of the already-advanced PC and take the lower eleven bits from three opcode bits and one operand byte. The long forms load a full 16-bit address. Relative branches add a signed byte to the address of the following instruction. The indirect form adds the accumulator to the data pointer. Results are registered: they appear one clock after the request and then hold until the next request.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is held and after its release, out_valid, stk_we, next_pc, the stack addresses and data, and sp_out are all zero until the first request.
- R2: br_kind 0 (sequential) gives next_pc = cur_pc + instr_len modulo 2^16.
- R3: br_kind 1 (in-page jump) gives next_pc = {bits 15:11 of cur_pc + instr_len, opc_hi as bits 10:8, op_b1 as bits 7:0}. For example, at 0x0345 with length 2, opc_hi 1 and op_b1 0x23, next_pc is 0x0123.
- R4: br_kind 2 (in-page call) forms its target exactly as R3 does and also pushes a return frame.
- R5: On a call, the low byte of the return address goes to sp_in+1 (stk_addr_lo/stk_data_lo) and the high byte to sp_in+2 (stk_addr_hi/stk_data_hi). stk_we is 1 and sp_out = sp_in+2, all modulo 256. For example, SP 0x07 with an in-page call at 0x0123 to 0x0345 gives 0x25 at 0x08, 0x01 at 0x09, SP 0x09 and PC 0x0345.
- R6: br_kind 3 (long jump) gives next_pc = {op_b1, op_b2}, with op_b1 as the high byte.
- R7: br_kind 4 (long call) targets {op_b1, op_b2} and pushes cur_pc + instr_len as its return address, following R5.
- R8: br_kind 5 (relative branch) with take = 1 gives cur_pc + instr_len + sign-extended offset, modulo 2^16. The offset is op_b2 when instr_len is 3 and op_b1 otherwise.
- R9: br_kind 5 with take = 0 gives cur_pc + instr_len.
- R10: br_kind 6 (compare-and-branch) advances past the instruction and adds the signed offset op_b2 only when take = 1.
- R11: br_kind 7 (indirect) gives next_pc = dptr + zero-extended acc, with the carry out of bit 15 dropped.
- R12: An in-page target follows the block of the next instruction. At 0x07FE with length 2 the target lies in the 2 KB block starting at 0x0800.
- R13: For every non-call form, stk_we is 0 and sp_out equals sp_in.
- R14: Results appear the cycle after in_valid. In a cycle with no request, out_valid and stk_we are 0 and next_pc holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request strobe |
| br_kind | input | 3 | Transfer form, encoded as in R2 to R11 |
| cur_pc | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes |
| opc_hi | input | 3 | Opcode bits 7:5 |
| op_b1 | input | 8 | First operand byte |
| op_b2 | input | 8 | Second operand byte |
| take | input | 1 | Branch condition result |
| sp_in | input | 8 | Current stack pointer |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| out_valid | output | 1 | Result strobe |
| next_pc | output | 16 | Next program counter |
| stk_we | output | 1 | Stack push enable |
| stk_addr_lo | output | 8 | Address for the return low byte |
| stk_data_lo | output | 8 | Return address bits 7:0 |
| stk_addr_hi | output | 8 | Address for the return high byte |
| stk_data_hi | output | 8 | Return address bits 15:8 |
| sp_out | output | 8 | Stack pointer after the operation |

## Verification
Every result passes through exactly one output register, so the values for a request driven before edge N are due right after edge N. The bench drives each request on a falling edge and drops in_valid on the next falling edge. It compares all outputs at that point, half a cycle after they are captured. A further idle falling edge is sampled to confirm that strobes clear and next_pc holds.

// File: rtl/pcbt_pkg.sv
package pcbt_pkg;
   typedef enum logic [2:0] {
      BK_SEQ       = 3'd0,
      BK_PAGE_JMP  = 3'd1,
      BK_PAGE_CALL = 3'd2,
      BK_LONG_JMP  = 3'd3,
      BK_LONG_CALL = 3'd4,
      BK_REL       = 3'd5,
      BK_CMP       = 3'd6,
      BK_IND       = 3'd7
   } br_kind_e;

   function automatic logic kind_is_call(br_kind_e k);
      return (k == BK_PAGE_CALL) || (k == BK_LONG_CALL);
   endfunction
endpackage

// File: rtl/pcbt_rel_calc.sv
module pcbt_rel_calc #(
   parameter int PC_W   = 16,
   parameter int BYTE_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic [PC_W-1:0]   cur_pc,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [BYTE_W-1:0] off_byte,
   output logic [PC_W-1:0]   seq_pc,
   output logic [PC_W-1:0]   rel_pc
);
   localparam int EXT_W = PC_W - BYTE_W;

   logic [PC_W-1:0] off_ext;

   generate
      if (PC_W <= BYTE_W) begin : g_bad_width
         $error("pcbt_rel_calc: PC_W must exceed BYTE_W");
      end
      if (LEN_W >= PC_W) begin : g_bad_len
         $error("pcbt_rel_calc: LEN_W must be narrower than PC_W");
      end
   endgenerate

   // Sign-extend the offset byte to the PC width.
   assign off_ext = {{EXT_W{off_byte[BYTE_W-1]}}, off_byte};

   // The relative base is the address of the following instruction.
   assign seq_pc = cur_pc + PC_W'(instr_len);
   assign rel_pc = seq_pc + off_ext;
endmodule

// File: rtl/pcbt_abs_calc.sv
module pcbt_abs_calc #(
   parameter int PC_W   = 16,
   parameter int BYTE_W = 8,
   parameter int PAGE_W = 11
) (
   input  logic [PC_W-1:0]             seq_pc,
   input  logic [PAGE_W-BYTE_W-1:0]    opc_hi,
   input  logic [BYTE_W-1:0]           op_b1,
   input  logic [BYTE_W-1:0]           op_b2,
   input  logic [BYTE_W-1:0]           acc,
   input  logic [PC_W-1:0]             dptr,
   output logic [PC_W-1:0]             page_pc,
   output logic [PC_W-1:0]             long_pc,
   output logic [PC_W-1:0]             ind_pc
);
   localparam int FIELD_W = PAGE_W - BYTE_W;
   localparam int LONG_W  = 2 * BYTE_W;

   generate
      if (FIELD_W < 1) begin : g_bad_field
         $error("pcbt_abs_calc: PAGE_W must exceed BYTE_W");
      end
      if (PAGE_W >= PC_W) begin : g_bad_page
         $error("pcbt_abs_calc: PAGE_W must be below PC_W");
      end
   endgenerate

   // The block bits come from the already-advanced PC.
   assign page_pc = {seq_pc[PC_W-1:PAGE_W], opc_hi, op_b1};

   generate
      if (PC_W == LONG_W) begin : g_long_exact
         assign long_pc = {op_b1, op_b2};
      end else if (PC_W > LONG_W) begin : g_long_pad
         assign long_pc = {{(PC_W-LONG_W){1'b0}}, op_b1, op_b2};
      end else begin : g_long_trim
         logic [LONG_W-1:0] long_full;
         assign long_full = {op_b1, op_b2};
         assign long_pc   = long_full[PC_W-1:0];
      end
   endgenerate

   // Indirect form: unsigned accumulator plus data pointer, carry out dropped.
   assign ind_pc = dptr + PC_W'(acc);
endmodule

// File: rtl/pcbt_call_frame.sv
module pcbt_call_frame #(
   parameter int PC_W   = 16,
   parameter int BYTE_W = 8,
   parameter int SP_W   = 8
) (
   input  logic              is_call,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic [SP_W-1:0]   sp_in,
   output logic              push_en,
   output logic [SP_W-1:0]   addr_lo,
   output logic [BYTE_W-1:0] data_lo,
   output logic [SP_W-1:0]   addr_hi,
   output logic [BYTE_W-1:0] data_hi,
   output logic [SP_W-1:0]   sp_next
);
   localparam int HI_W = PC_W - BYTE_W;

   generate
      if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_split
         $error("pcbt_call_frame: PC_W must lie in (BYTE_W, 2*BYTE_W]");
      end
   endgenerate

   // Low byte is pushed first, at SP+1; the high byte follows at SP+2.
   assign push_en = is_call;
   assign addr_lo = sp_in + SP_W'(1);
   assign addr_hi = sp_in + SP_W'(2);
   assign data_lo = ret_pc[BYTE_W-1:0];
   assign sp_next = is_call ? addr_hi : sp_in;

   generate
      if (HI_W == BYTE_W) begin : g_hi_exact
         assign data_hi = ret_pc[PC_W-1:BYTE_W];
      end else begin : g_hi_pad
         assign data_hi = {{(BYTE_W-HI_W){1'b0}}, ret_pc[PC_W-1:BYTE_W]};
      end
   endgenerate
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
   parameter int PC_W    = 16,
   parameter int BYTE_W  = 8,
   parameter int SP_W    = 8,
   parameter int LEN_W   = 2,
   parameter int PAGE_W  = 11,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [2:0]                 br_kind,
   input  logic [PC_W-1:0]            cur_pc,
   input  logic [LEN_W-1:0]           instr_len,
   input  logic [PAGE_W-BYTE_W-1:0]   opc_hi,
   input  logic [BYTE_W-1:0]          op_b1,
   input  logic [BYTE_W-1:0]          op_b2,
   input  logic                       take,
   input  logic [SP_W-1:0]            sp_in,
   input  logic [BYTE_W-1:0]          acc,
   input  logic [PC_W-1:0]            dptr,
   output logic                       out_valid,
   output logic [PC_W-1:0]            next_pc,
   output logic                       stk_we,
   output logic [SP_W-1:0]            stk_addr_lo,
   output logic [BYTE_W-1:0]          stk_data_lo,
   output logic [SP_W-1:0]            stk_addr_hi,
   output logic [BYTE_W-1:0]          stk_data_hi,
   output logic [SP_W-1:0]            sp_out
);
   import pcbt_pkg::*;

   localparam logic [LEN_W-1:0] LEN_THREE = LEN_W'(3);

   br_kind_e          kind;
   logic              is_call;
   logic [BYTE_W-1:0] off_byte;
   logic [PC_W-1:0]   seq_pc, rel_pc, page_pc, long_pc, ind_pc;
   logic [PC_W-1:0]   pc_d;
   logic              we_d;
   logic [SP_W-1:0]   addr_lo_d, addr_hi_d, sp_d;
   logic [BYTE_W-1:0] data_lo_d, data_hi_d;

   assign kind    = br_kind_e'(br_kind);
   assign is_call = kind_is_call(kind);

   // The offset is the last instruction byte: the second operand for
   // three-byte forms, the first operand otherwise.
   always_comb begin
      if (kind == BK_CMP || instr_len == LEN_THREE) off_byte = op_b2;
      else                                           off_byte = op_b1;
   end

   pcbt_rel_calc #(.PC_W(PC_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_rel (
      .cur_pc    (cur_pc),
      .instr_len (instr_len),
      .off_byte  (off_byte),
      .seq_pc    (seq_pc),
      .rel_pc    (rel_pc)
   );

   pcbt_abs_calc #(.PC_W(PC_W), .BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_abs (
      .seq_pc  (seq_pc),
      .opc_hi  (opc_hi),
      .op_b1   (op_b1),
      .op_b2   (op_b2),
      .acc     (acc),
      .dptr    (dptr),
      .page_pc (page_pc),
      .long_pc (long_pc),
      .ind_pc  (ind_pc)
   );

   pcbt_call_frame #(.PC_W(PC_W), .BYTE_W(BYTE_W), .SP_W(SP_W)) u_frame (
      .is_call (is_call),
      .ret_pc  (seq_pc),
      .sp_in   (sp_in),
      .push_en (we_d),
      .addr_lo (addr_lo_d),
      .data_lo (data_lo_d),
      .addr_hi (addr_hi_d),
      .data_hi (data_hi_d),
      .sp_next (sp_d)
   );

   // Target selection.
   always_comb begin
      unique case (kind)
         BK_SEQ:                   pc_d = seq_pc;
         BK_PAGE_JMP, BK_PAGE_CALL: pc_d = page_pc;
         BK_LONG_JMP, BK_LONG_CALL: pc_d = long_pc;
         BK_REL, BK_CMP:           pc_d = take ? rel_pc : seq_pc;
         BK_IND:                   pc_d = ind_pc;
         default:                  pc_d = seq_pc;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               stk_we      <= 1'b0;
               next_pc     <= '0;
               stk_addr_lo <= '0;
               stk_data_lo <= '0;
               stk_addr_hi <= '0;
               stk_data_hi <= '0;
               sp_out      <= '0;
            end else begin
               out_valid <= in_valid;
               stk_we    <= in_valid & we_d;
               if (in_valid) begin
                  next_pc     <= pc_d;
                  stk_addr_lo <= addr_lo_d;
                  stk_data_lo <= data_lo_d;
                  stk_addr_hi <= addr_hi_d;
                  stk_data_hi <= data_hi_d;
                  sp_out      <= sp_d;
               end
            end
         end

         // R2: sequential flow advances by the instruction length
         assert_seq_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && kind == BK_SEQ |=>
               next_pc == $past(cur_pc) + PC_W'($past(instr_len)));

         // R9 / R10: untaken branches fall through
         assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (kind == BK_REL || kind == BK_CMP) && !take |=>
               next_pc == $past(cur_pc) + PC_W'($past(instr_len)));

         // R12: in-page target keeps the block of the following instruction
         assert_page_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (kind == BK_PAGE_JMP || kind == BK_PAGE_CALL) |=>
               (next_pc >> PAGE_W) ==
               (($past(cur_pc) + PC_W'($past(instr_len))) >> PAGE_W));

         // R5: a call pushes and moves the stack pointer by two
         assert_call_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && is_call |=> stk_we && sp_out == $past(sp_in) + SP_W'(2));

         // R5: high byte lands directly above the low byte
         assert_push_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
            stk_we |-> stk_addr_hi == stk_addr_lo + SP_W'(1));

         // R13: non-call forms leave the stack alone
         assert_no_push_R13: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && !is_call |=> !stk_we && sp_out == $past(sp_in));

         // R14: idle cycles drop the strobes and hold the PC
         assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid && !stk_we && $stable(next_pc));
      end else begin : g_comb
         assign out_valid   = in_valid;
         assign stk_we      = in_valid & we_d;
         assign next_pc     = pc_d;
         assign stk_addr_lo = addr_lo_d;
         assign stk_data_lo = data_lo_d;
         assign stk_addr_hi = addr_hi_d;
         assign stk_data_hi = data_hi_d;
         assign sp_out      = sp_d;
      end
   endgenerate
endmodule

// File: tb/sim_pc_branch_unit.sv
module sim_pc_branch_unit;
   typedef struct packed {
      logic [2:0]  kind;
      logic [1:0]  len;
      logic [15:0] pc;
      logic [2:0]  opc;
      logic [7:0]  b1;
      logic [7:0]  b2;
      logic        take;
      logic [15:0] dptr;
      logic [7:0]  acc;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 2'd1, 16'h1000, 3'd0, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 16'h1001},
      '{3'd0, 2'd3, 16'hFFFE, 3'd0, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 16'h0001},
      '{3'd1, 2'd2, 16'h0345, 3'd1, 8'h23, 8'h00, 1'b0, 16'h0000, 8'h00, 16'h0123},
      '{3'd1, 2'd2, 16'hA7F0, 3'd7, 8'h10, 8'h00, 1'b0, 16'h0000, 8'h00, 16'hA710},
      '{3'd3, 2'd3, 16'h0100, 3'd0, 8'hBE, 8'hEF, 1'b0, 16'h0000, 8'h00, 16'hBEEF},
      '{3'd5, 2'd2, 16'h2000, 3'd0, 8'h10, 8'h00, 1'b1, 16'h0000, 8'h00, 16'h2012},
      '{3'd5, 2'd2, 16'h2000, 3'd0, 8'h80, 8'h00, 1'b1, 16'h0000, 8'h00, 16'h1F82},
      '{3'd5, 2'd3, 16'h3000, 3'd0, 8'h55, 8'hFE, 1'b1, 16'h0000, 8'h00, 16'h3001},
      '{3'd5, 2'd2, 16'h2000, 3'd0, 8'h80, 8'h00, 1'b0, 16'h0000, 8'h00, 16'h2002},
      '{3'd5, 2'd2, 16'h0000, 3'd0, 8'hF0, 8'h00, 1'b1, 16'h0000, 8'h00, 16'hFFF2},
      '{3'd6, 2'd3, 16'h4000, 3'd0, 8'h60, 8'h7F, 1'b1, 16'h0000, 8'h00, 16'h4082},
      '{3'd6, 2'd3, 16'h4000, 3'd0, 8'h60, 8'h7F, 1'b0, 16'h0000, 8'h00, 16'h4003},
      '{3'd7, 2'd1, 16'h5000, 3'd0, 8'h00, 8'h00, 1'b0, 16'h1234, 8'hFF, 16'h1333},
      '{3'd7, 2'd1, 16'h5000, 3'd0, 8'h00, 8'h00, 1'b0, 16'hFFF0, 8'h20, 16'h0010},
      '{3'd1, 2'd2, 16'h07FE, 3'd0, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 16'h0800}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  br_kind = '0;
   logic [15:0] cur_pc = '0;
   logic [1:0]  instr_len = '0;
   logic [2:0]  opc_hi = '0;
   logic [7:0]  op_b1 = '0, op_b2 = '0;
   logic        take = 1'b0;
   logic [7:0]  sp_in = '0, acc = '0;
   logic [15:0] dptr = '0;
   logic        out_valid, stk_we;
   logic [15:0] next_pc;
   logic [7:0]  stk_addr_lo, stk_data_lo, stk_addr_hi, stk_data_hi, sp_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   pc_branch_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_kind(br_kind),
      .cur_pc(cur_pc), .instr_len(instr_len), .opc_hi(opc_hi),
      .op_b1(op_b1), .op_b2(op_b2), .take(take), .sp_in(sp_in),
      .acc(acc), .dptr(dptr), .out_valid(out_valid), .next_pc(next_pc),
      .stk_we(stk_we), .stk_addr_lo(stk_addr_lo), .stk_data_lo(stk_data_lo),
      .stk_addr_hi(stk_addr_hi), .stk_data_hi(stk_data_hi), .sp_out(sp_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Drive one request on a falling edge, release it on the next falling
   // edge; the registered results are then stable and due.
   task automatic issue(input logic [2:0] k, input logic [1:0] l, input logic [15:0] pc,
                        input logic [2:0] oh, input logic [7:0] a1, input logic [7:0] a2,
                        input logic tk, input logic [7:0] sp, input logic [7:0] ac,
                        input logic [15:0] dp);
      @(negedge clk);
      in_valid = 1'b1; br_kind = k; instr_len = l; cur_pc = pc; opc_hi = oh;
      op_b1 = a1; op_b2 = a2; take = tk; sp_in = sp; acc = ac; dptr = dp;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic string req_of(input vec_t v, input int idx);
      if (idx == NV-1) return "R12";
      case (v.kind)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd3: return "R6";
         3'd5: return v.take ? "R8" : "R9";
         3'd6: return "R10";
         default: return "R11";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", 32'(out_valid), 32'h0);
      chk("R1 stk_we", 32'(stk_we), 32'h0);
      chk("R1 next_pc", 32'(next_pc), 32'h0);
      chk("R1 sp_out", 32'(sp_out), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({out_valid, stk_we, next_pc, stk_addr_lo, sp_out}), 32'h0);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].kind, VECS[i].len, VECS[i].pc, VECS[i].opc, VECS[i].b1,
               VECS[i].b2, VECS[i].take, 8'h30, VECS[i].acc, VECS[i].dptr);
         chk({req_of(VECS[i], i), " next_pc"}, 32'(next_pc), 32'(VECS[i].exp));
         chk("R14 out_valid", 32'(out_valid), 32'h1);
         chk("R13 stk_we", 32'(stk_we), 32'h0);
         chk("R13 sp_out", 32'(sp_out), 32'h30);
      end

      // R4 / R5: in-page call, SP 0x07 at 0x0123 to 0x0345
      issue(3'd2, 2'd2, 16'h0123, 3'd3, 8'h45, 8'h00, 1'b0, 8'h07, 8'h00, 16'h0);
      chk("R4 next_pc", 32'(next_pc), 32'h0345);
      chk("R5 stk_we", 32'(stk_we), 32'h1);
      chk("R5 addr_lo", 32'(stk_addr_lo), 32'h08);
      chk("R5 data_lo", 32'(stk_data_lo), 32'h25);
      chk("R5 addr_hi", 32'(stk_addr_hi), 32'h09);
      chk("R5 data_hi", 32'(stk_data_hi), 32'h01);
      chk("R5 sp_out", 32'(sp_out), 32'h09);

      // R14: idle cycle clears strobes and holds PC
      @(negedge clk);
      chk("R14 idle out_valid", 32'(out_valid), 32'h0);
      chk("R14 idle stk_we", 32'(stk_we), 32'h0);
      chk("R14 idle next_pc", 32'(next_pc), 32'h0345);

      // R7: long call at 0x1234, three bytes, SP 0x7F
      issue(3'd4, 2'd3, 16'h1234, 3'd0, 8'h56, 8'h78, 1'b0, 8'h7F, 8'h00, 16'h0);
      chk("R7 next_pc", 32'(next_pc), 32'h5678);
      chk("R7 data_lo", 32'(stk_data_lo), 32'h37);
      chk("R7 data_hi", 32'(stk_data_hi), 32'h12);
      chk("R7 addr_lo", 32'(stk_addr_lo), 32'h80);
      chk("R7 sp_out", 32'(sp_out), 32'h81);

      // R5: stack pointer wraps modulo 256
      issue(3'd4, 2'd3, 16'hFFFD, 3'd0, 8'h00, 8'h10, 1'b0, 8'hFF, 8'h00, 16'h0);
      chk("R5 wrap addr_lo", 32'(stk_addr_lo), 32'h00);
      chk("R5 wrap addr_hi", 32'(stk_addr_hi), 32'h01);
      chk("R5 wrap sp_out", 32'(sp_out), 32'h01);
      chk("R7 wrap ret", 32'({stk_data_hi, stk_data_lo}), 32'h0000);
      chk("R6 long target", 32'(next_pc), 32'h0010);

      // R10 versus R8: compare form takes the offset from the third byte
      issue(3'd6, 2'd3, 16'h6000, 3'd0, 8'hFF, 8'h02, 1'b1, 8'h30, 8'h00, 16'h0);
      chk("R10 offset byte", 32'(next_pc), 32'h6005);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule